// File: doc/BRIEF.md
# Character-Row CRT Timing Generator

This block derives every raster timing signal of a character-cell text display from one character-rate clock. Three cascaded counters track the character column within a scan line, the scan line within a character row, and the character row within a frame. Decodes of those counts form horizontal and vertical sync, a composite sync with wide vertical pulses, composite blanking, a cursor-line strobe, an end-of-page pulse, a per-cell-group load strobe and a slow blink clock. The blink clock is divided from the frame rate.

Composite sync and composite blanking leave through a two-character alignment delay. This lines them up with video that has passed through a fetch-and-shift path two characters deep. An undelayed, active-low copy of blanking is also provided for logic that works ahead of that path. A build option adds blanking of scan lines 9 to 11 (zero-based) of every row, for a 50 Hz frame variant. Frame geometry and pulse placement are all parameters.

Top module: `crt_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all counters clear and the outputs settle to `hsync`, `vsync`, `csync`, `eop`, `cursor_line` and `blink` low, `cblank` and `load_n` high, and `blank_n` low.
- R2: After reset the position p (counted in clocks from the first edge with `rst` low) maps to column p mod CHARS_PER_LINE, scan (p / CHARS_PER_LINE) mod SCANS_PER_ROW, and row (p / (CHARS_PER_LINE*SCANS_PER_ROW)) mod ROWS_PER_FRAME. The registered outputs after edge n show position n-1, so a frame repeats every CHARS_PER_LINE*SCANS_PER_ROW*ROWS_PER_FRAME clocks.
- R3: `hsync` is high exactly for columns HSYNC_START to HSYNC_END-1 of every line.
- R4: `blank_n` is low when the column is at least HBLANK_START or the row is at least ROWS_SHOWN (the final two rows), and high otherwise when FIFTY_HZ is 0.
- R5: With FIFTY_HZ set, `blank_n` is additionally low on scan lines 9, 10 and 11 of every row.
- R6: `vsync` is high for VSYNC_SCANS whole lines, starting at scan VSYNC_FIRST_SCAN of row ROWS_SHOWN, once per frame.
- R7: The undelayed composite sync is high for columns HSYNC_START to HSYNC_START+VSERR_WIDTH-1 on the `vsync` lines, and equals the `hsync` pattern elsewhere. `csync` presents it two clocks later, so `csync` after edge n shows position n-3.
- R8: `cblank` equals the inverse of `blank_n` two clocks earlier.
- R9: `cursor_line` is high for the whole of scan line CURSOR_SCAN (default 8: count bits 0 and 1 low, bit 3 high) in every displayed row, and low elsewhere.
- R10: `eop` is high for exactly one full line, scan 0 of row ROWS_SHOWN (right after the last displayed row), once per frame.
- R11: `load_n` is low for one clock whenever column mod LOAD_GROUP equals LOAD_GROUP-1 (default LOAD_GROUP 8), so it pulses every 8 clocks.
- R12: `blink` toggles at the clock where `eop` rises, on every (BLINK_DIV/2)-th such rise (default 6th). Its full period is therefore BLINK_DIV frames, and the first toggle comes at the 6th rise after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| csync | output | 1 | Composite sync, two-clock aligned, active high |
| cblank | output | 1 | Composite blanking, two-clock aligned, active high |
| blank_n | output | 1 | Undelayed composite blanking, active low |
| blink | output | 1 | Blink-rate clock derived from frame rate |
| cursor_line | output | 1 | High on the cursor scan line of displayed rows |
| eop | output | 1 | End-of-page pulse, one line wide |
| load_n | output | 1 | Active-low one-clock load strobe per cell group |

## Verification
The only inputs are the clock and a synchronous reset. The alignment-delay properties assume that reset is held for at least two clock edges from time zero, so the two-cycle look-back always lands on reset values or on live data. The stimulus holds reset for four edges at start-up and for three edges when it re-applies reset partway through a frame. Reset is driven only on falling clock edges, so it is never ambiguous at the edge where the design samples it.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

   // Two-character alignment between the counters and the delayed video path
   localparam int ALIGN_DELAY = 2;

   // First zero-based scan line blanked in the 50 Hz variant, and how many
   localparam int EXTRA_FIRST_SCAN = 9;
   localparam int EXTRA_SCAN_COUNT = 3;

   // Raw (combinational) decodes of the raster position
   typedef struct packed {
      logic hsync;
      logic vsync;
      logic csync;
      logic blank;
      logic cursor;
      logic eop_line;
      logic load_slot;
      logic frame_mark;
   } crt_raw_t;

endpackage

// File: rtl/crt_mod_counter.sv
module crt_mod_counter #(
   parameter int MODULUS = 2,
   localparam int W = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   output logic [W-1:0] count,
   output logic         wrap
);

   localparam logic [W-1:0] LAST = W'(MODULUS - 1);

   assign wrap = step && (count == LAST);

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (step)
         count <= (count == LAST) ? '0 : count + 1'b1;
   end

endmodule

// File: rtl/crt_raster_decode.sv
module crt_raster_decode
   import crt_timing_pkg::*;
#(
   parameter int H_W              = 7,
   parameter int S_W              = 4,
   parameter int R_W              = 5,
   parameter int HBLANK_START     = 80,
   parameter int HSYNC_START      = 84,
   parameter int HSYNC_END        = 92,
   parameter int VSERR_WIDTH      = 16,
   parameter int ROWS_SHOWN       = 24,
   parameter int VSYNC_FIRST_SCAN = 2,
   parameter int VSYNC_SCANS      = 4,
   parameter int CURSOR_SCAN      = 8,
   parameter int LOAD_GROUP       = 8,
   parameter bit FIFTY_HZ         = 1'b0
) (
   input  logic [H_W-1:0] col,
   input  logic [S_W-1:0] scan,
   input  logic [R_W-1:0] row,
   output crt_raw_t       raw
);

   localparam int LOAD_MASK = LOAD_GROUP - 1;

   logic extra_blank;

   // Variant selection: extra character-row blanking for the 50 Hz frame
   generate
      if (FIFTY_HZ) begin : g_fifty
         always_comb begin
            int s;
            s = int'(scan);
            extra_blank = (s >= EXTRA_FIRST_SCAN) &&
                          (s < EXTRA_FIRST_SCAN + EXTRA_SCAN_COUNT);
         end
      end else begin : g_sixty
         assign extra_blank = 1'b0;
      end
   endgenerate

   always_comb begin
      int c;
      int s;
      int r;
      logic in_vsync;
      logic in_hsync;
      c = int'(col);
      s = int'(scan);
      r = int'(row);
      in_hsync = (c >= HSYNC_START) && (c < HSYNC_END);
      in_vsync = (r == ROWS_SHOWN) && (s >= VSYNC_FIRST_SCAN) &&
                 (s < VSYNC_FIRST_SCAN + VSYNC_SCANS);
      raw.hsync      = in_hsync;
      raw.vsync      = in_vsync;
      raw.csync      = in_vsync ? ((c >= HSYNC_START) && (c < HSYNC_START + VSERR_WIDTH))
                                : in_hsync;
      raw.blank      = (c >= HBLANK_START) || (r >= ROWS_SHOWN) || extra_blank;
      raw.cursor     = (r < ROWS_SHOWN) && (s == CURSOR_SCAN);
      raw.eop_line   = (r == ROWS_SHOWN) && (s == 0);
      raw.load_slot  = ((c & LOAD_MASK) == LOAD_MASK);
      raw.frame_mark = (r == ROWS_SHOWN) && (s == 0) && (c == 0);
   end

endmodule

// File: rtl/crt_blink_div.sv
module crt_blink_div #(
   parameter int BLINK_DIV = 12,
   localparam int HALF = BLINK_DIV / 2,
   localparam int W = (HALF > 1) ? $clog2(HALF) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic blink
);

   localparam logic [W-1:0] LAST = W'(HALF - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         blink <= 1'b0;
      end else if (tick) begin
         if (cnt == LAST) begin
            cnt   <= '0;
            blink <= ~blink;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/crt_delay_pipe.sv
module crt_delay_pipe #(
   parameter int WIDTH = 2,
   parameter int DEPTH = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (DEPTH == 0) begin : g_wire
         assign dout = din;
      end else begin : g_regs
         logic [DEPTH-1:0][WIDTH-1:0] stage;
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) stage[i] <= RST_VAL;
            end else begin
               stage[0] <= din;
               for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
            end
         end
         assign dout = stage[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
   import crt_timing_pkg::*;
#(
   parameter int CHARS_PER_LINE   = 104,
   parameter int HBLANK_START     = 80,
   parameter int HSYNC_START      = 84,
   parameter int HSYNC_END        = 92,
   parameter int VSERR_WIDTH      = 16,
   parameter int SCANS_PER_ROW    = 12,
   parameter int ROWS_PER_FRAME   = 26,
   parameter int ROWS_SHOWN       = 24,
   parameter int VSYNC_FIRST_SCAN = 2,
   parameter int VSYNC_SCANS      = 4,
   parameter int CURSOR_SCAN      = 8,
   parameter int BLINK_DIV        = 12,
   parameter int LOAD_GROUP       = 8,
   parameter bit FIFTY_HZ         = 1'b0
) (
   input  logic clk,
   input  logic rst,
   output logic hsync,
   output logic vsync,
   output logic csync,
   output logic cblank,
   output logic blank_n,
   output logic blink,
   output logic cursor_line,
   output logic eop,
   output logic load_n
);

   localparam int H_W = (CHARS_PER_LINE > 1) ? $clog2(CHARS_PER_LINE) : 1;
   localparam int S_W = (SCANS_PER_ROW > 1)  ? $clog2(SCANS_PER_ROW)  : 1;
   localparam int R_W = (ROWS_PER_FRAME > 1) ? $clog2(ROWS_PER_FRAME) : 1;

   // Elaboration-time parameter checks
   generate
      if (HSYNC_START < HBLANK_START || HSYNC_END <= HSYNC_START ||
          HSYNC_END > CHARS_PER_LINE || HBLANK_START < 1) begin : g_bad_horiz
         $error("crt_timing_gen: horizontal sync must sit inside horizontal blanking");
      end
      if (HSYNC_START + VSERR_WIDTH > CHARS_PER_LINE || VSERR_WIDTH < 1) begin : g_bad_serr
         $error("crt_timing_gen: wide vertical pulse must fit in one line");
      end
      if (ROWS_SHOWN < 1 || ROWS_SHOWN >= ROWS_PER_FRAME) begin : g_bad_rows
         $error("crt_timing_gen: at least one blanked row is required");
      end
      if (VSYNC_FIRST_SCAN < 1 || VSYNC_SCANS < 1 ||
          VSYNC_FIRST_SCAN + VSYNC_SCANS > SCANS_PER_ROW) begin : g_bad_vsync
         $error("crt_timing_gen: vertical sync must fit inside the first blanked row");
      end
      if (CURSOR_SCAN >= SCANS_PER_ROW) begin : g_bad_cursor
         $error("crt_timing_gen: cursor scan line out of range");
      end
      if (FIFTY_HZ && SCANS_PER_ROW < EXTRA_FIRST_SCAN + EXTRA_SCAN_COUNT) begin : g_bad_fifty
         $error("crt_timing_gen: 50 Hz variant needs at least 12 scan lines per row");
      end
      if (BLINK_DIV < 2 || (BLINK_DIV % 2) != 0) begin : g_bad_blink
         $error("crt_timing_gen: blink divisor must be even and at least 2");
      end
      if (LOAD_GROUP < 2 || (LOAD_GROUP & (LOAD_GROUP - 1)) != 0 ||
          (CHARS_PER_LINE % LOAD_GROUP) != 0) begin : g_bad_load
         $error("crt_timing_gen: load group must be a power of two dividing the line");
      end
   endgenerate

   // Cascaded raster counters
   logic [H_W-1:0] col;
   logic [S_W-1:0] scan;
   logic [R_W-1:0] row;
   logic           line_end;
   logic           row_end;
   logic           frame_end;

   crt_mod_counter #(.MODULUS(CHARS_PER_LINE)) u_col (
      .clk(clk), .rst(rst), .step(1'b1), .count(col), .wrap(line_end)
   );

   crt_mod_counter #(.MODULUS(SCANS_PER_ROW)) u_scan (
      .clk(clk), .rst(rst), .step(line_end), .count(scan), .wrap(row_end)
   );

   crt_mod_counter #(.MODULUS(ROWS_PER_FRAME)) u_row (
      .clk(clk), .rst(rst), .step(row_end), .count(row), .wrap(frame_end)
   );

   // Position decode
   crt_raw_t raw;

   crt_raster_decode #(
      .H_W(H_W), .S_W(S_W), .R_W(R_W),
      .HBLANK_START(HBLANK_START), .HSYNC_START(HSYNC_START), .HSYNC_END(HSYNC_END),
      .VSERR_WIDTH(VSERR_WIDTH), .ROWS_SHOWN(ROWS_SHOWN),
      .VSYNC_FIRST_SCAN(VSYNC_FIRST_SCAN), .VSYNC_SCANS(VSYNC_SCANS),
      .CURSOR_SCAN(CURSOR_SCAN), .LOAD_GROUP(LOAD_GROUP), .FIFTY_HZ(FIFTY_HZ)
   ) u_decode (
      .col(col), .scan(scan), .row(row), .raw(raw)
   );

   // Output register stage (glitch-free outputs)
   logic csync_q;
   logic blank_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hsync       <= 1'b0;
         vsync       <= 1'b0;
         csync_q     <= 1'b0;
         blank_q     <= 1'b1;
         cursor_line <= 1'b0;
         eop         <= 1'b0;
         load_n      <= 1'b1;
      end else begin
         hsync       <= raw.hsync;
         vsync       <= raw.vsync;
         csync_q     <= raw.csync;
         blank_q     <= raw.blank;
         cursor_line <= raw.cursor;
         eop         <= raw.eop_line;
         load_n      <= ~raw.load_slot;
      end
   end

   assign blank_n = ~blank_q;

   // Blink clock divided from the start of vertical blanking
   crt_blink_div #(.BLINK_DIV(BLINK_DIV)) u_blink (
      .clk(clk), .rst(rst), .tick(raw.frame_mark), .blink(blink)
   );

   // Two-character alignment of composite sync and blanking
   logic [1:0] aligned;

   crt_delay_pipe #(.WIDTH(2), .DEPTH(ALIGN_DELAY), .RST_VAL(2'b01)) u_align (
      .clk(clk), .rst(rst), .din({csync_q, blank_q}), .dout(aligned)
   );

   assign csync  = aligned[1];
   assign cblank = aligned[0];

endmodule

// File: rtl/crt_timing_gen_chk.sv
module crt_timing_gen_chk (
   input logic clk,
   input logic rst,
   input logic hsync,
   input logic vsync,
   input logic csync,
   input logic cblank,
   input logic blank_n,
   input logic blink,
   input logic cursor_line,
   input logic eop,
   input logic load_n,
   input logic csync_early,
   input logic frame_end
);

   // R8: delayed blanking is the inverse of undelayed blanking two clocks before
   p_cblank_lag_r8: assert property (@(posedge clk) disable iff (rst)
      cblank == !$past(blank_n, 2));

   // R7: composite sync leaves two clocks after its undelayed form
   p_csync_lag_r7: assert property (@(posedge clk) disable iff (rst)
      csync == $past(csync_early, 2));

   // R11: load strobe is one clock wide
   p_load_narrow_r11: assert property (@(posedge clk) disable iff (rst)
      !load_n |=> load_n);

   // R3: horizontal sync always falls inside blanking
   p_hsync_blanked_r3: assert property (@(posedge clk) disable iff (rst)
      hsync |-> !blank_n);

   // R6: vertical sync always falls inside blanking
   p_vsync_blanked_r6: assert property (@(posedge clk) disable iff (rst)
      vsync |-> !blank_n);

   // R10: end-of-page occurs in a blanked row
   p_eop_blanked_r10: assert property (@(posedge clk) disable iff (rst)
      eop |-> !blank_n);

   // R9: cursor line never coincides with the vertical interval
   p_cursor_visible_r9: assert property (@(posedge clk) disable iff (rst)
      cursor_line |-> (!vsync && !eop));

   // R12: blink only changes where end-of-page rises
   p_blink_on_eop_r12: assert property (@(posedge clk) disable iff (rst)
      !$stable(blink) |-> $rose(eop));

   // R2: the last position of a frame lies in a blanked row with no end-of-page
   p_frame_end_blanked_r2: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> (!blank_n && !eop));

endmodule

bind crt_timing_gen crt_timing_gen_chk u_chk (
   .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .csync(csync),
   .cblank(cblank), .blank_n(blank_n), .blink(blink), .cursor_line(cursor_line),
   .eop(eop), .load_n(load_n), .csync_early(csync_q), .frame_end(frame_end)
);

// File: tb/crt_timing_gen_test.sv
module crt_timing_gen_test;

   localparam int C   = 32;
   localparam int HB  = 24;
   localparam int HS  = 26;
   localparam int HE  = 29;
   localparam int WL  = 5;
   localparam int S   = 12;
   localparam int R   = 26;
   localparam int SH  = 24;
   localparam int VF  = 2;
   localparam int VN  = 4;
   localparam int CUR = 8;
   localparam int BD  = 12;
   localparam int LG  = 8;
   localparam int F   = C * S * R;
   localparam int VB_BASE = SH * S * C;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic hsync, vsync, csync, cblank, blank_n, blink, cursor_line, eop, load_n;
   logic f_hsync, f_vsync, f_csync, f_cblank, f_blank_n, f_blink, f_cursor, f_eop, f_load_n;

   crt_timing_gen #(
      .CHARS_PER_LINE(C), .HBLANK_START(HB), .HSYNC_START(HS), .HSYNC_END(HE),
      .VSERR_WIDTH(WL), .SCANS_PER_ROW(S), .ROWS_PER_FRAME(R), .ROWS_SHOWN(SH),
      .VSYNC_FIRST_SCAN(VF), .VSYNC_SCANS(VN), .CURSOR_SCAN(CUR),
      .BLINK_DIV(BD), .LOAD_GROUP(LG), .FIFTY_HZ(1'b0)
   ) uut (
      .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .csync(csync),
      .cblank(cblank), .blank_n(blank_n), .blink(blink), .cursor_line(cursor_line),
      .eop(eop), .load_n(load_n)
   );

   crt_timing_gen #(
      .CHARS_PER_LINE(C), .HBLANK_START(HB), .HSYNC_START(HS), .HSYNC_END(HE),
      .VSERR_WIDTH(WL), .SCANS_PER_ROW(S), .ROWS_PER_FRAME(R), .ROWS_SHOWN(SH),
      .VSYNC_FIRST_SCAN(VF), .VSYNC_SCANS(VN), .CURSOR_SCAN(CUR),
      .BLINK_DIV(BD), .LOAD_GROUP(LG), .FIFTY_HZ(1'b1)
   ) uut_50hz (
      .clk(clk), .rst(rst), .hsync(f_hsync), .vsync(f_vsync), .csync(f_csync),
      .cblank(f_cblank), .blank_n(f_blank_n), .blink(f_blink), .cursor_line(f_cursor),
      .eop(f_eop), .load_n(f_load_n)
   );

   int tests = 0;
   int fails = 0;
   int edges = 0;
   int errcnt [1:12];
   int toggles = 0;
   int toggle_at [0:3];
   logic prev_blink = 1'b0;

   always @(posedge clk) begin
      if (rst) edges <= 0;
      else     edges <= edges + 1;
   end

   task automatic check_eq(input string req, input int act, input int exp, input string what);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Expected bits {hs, vs, cs_early, blank, cursor, eop, load_n} at position p
   function automatic logic [6:0] model(input int p, input bit fifty);
      int h, s, r;
      logic hs, vs, cs, bl, cu, eo, ld;
      h  = p % C;
      s  = (p / C) % S;
      r  = (p / (C * S)) % R;
      hs = (h >= HS) && (h < HE);
      vs = (r == SH) && (s >= VF) && (s < VF + VN);
      cs = vs ? ((h >= HS) && (h < HS + WL)) : hs;
      bl = (h >= HB) || (r >= SH) || (fifty && (s >= 9) && (s <= 11));
      cu = (r < SH) && (s == CUR);
      eo = (r == SH) && (s == 0);
      ld = !((h % LG) == LG - 1);
      return {hs, vs, cs, bl, cu, eo, ld};
   endfunction

   function automatic logic blink_model(input int p);
      int occ;
      if (p < VB_BASE) return 1'b0;
      occ = (p - VB_BASE) / F + 1;
      return ((occ / (BD / 2)) % 2) == 1;
   endfunction

   function automatic void note(input int req, input logic act, input logic exp);
      if (act !== exp) errcnt[req]++;
   endfunction

   // Cycle-by-cycle comparison against the position model
   always @(negedge clk) begin
      int n;
      logic [6:0] e1, e3, f1;
      logic eb;
      n = edges;
      if (n == 0) begin
         note(1, hsync, 1'b0);  note(1, vsync, 1'b0);  note(1, csync, 1'b0);
         note(1, cblank, 1'b1); note(1, blank_n, 1'b0); note(1, blink, 1'b0);
         note(1, cursor_line, 1'b0); note(1, eop, 1'b0); note(1, load_n, 1'b1);
      end else begin
         e1 = model(n - 1, 1'b0);
         f1 = model(n - 1, 1'b1);
         eb = blink_model(n - 1);
         note(3, hsync, e1[6]);
         note(6, vsync, e1[5]);
         note(4, blank_n, ~e1[3]);
         note(5, f_blank_n, ~f1[3]);
         note(9, cursor_line, e1[2]);
         note(10, eop, e1[1]);
         note(11, load_n, e1[0]);
         note(12, blink, eb);
         note(12, f_blink, eb);
         if (n >= 3) begin
            e3 = model(n - 3, 1'b0);
            note(7, csync, e3[4]);
            note(8, cblank, e3[3]);
            note(8, f_cblank, model(n - 3, 1'b1) >> 3 & 7'd1);
         end else begin
            note(7, csync, 1'b0);
            note(8, cblank, 1'b1);
         end
         if (blink !== prev_blink) begin
            if (toggles < 4) toggle_at[toggles] = n;
            toggles++;
         end
      end
      prev_blink = blink;
   end

   task automatic wait_edges(input int target);
      while (edges < target) @(negedge clk);
   endtask

   task automatic test_reset();
      repeat (4) @(negedge clk);
      check_eq("R1", int'({hsync, vsync, csync, eop, cursor_line, blink}), 0, "active-high outputs in reset");
      check_eq("R1", int'({cblank, load_n, blank_n}), 6, "cblank/load_n/blank_n in reset");
      check_eq("R1", int'({f_cblank, f_load_n, f_blank_n}), 6, "50 Hz instance blank/load in reset");
   endtask

   task automatic test_raster();
      int hs_run = 0, hs_bad = 0, vs_run = 0, vs_bad = 0;
      int cs_run = 0, wide = 0, eo_run = 0, eo_bad = 0, eo_rise = 0;
      int first_rise = -1, rise_gap = 0, last_low = -1, ld_bad = 0;
      logic p_hs = 0, p_vs = 0, p_cs = 0, p_eo = 0;
      for (int i = 0; i < 2 * F; i++) begin
         @(negedge clk);
         if (hsync) hs_run++; else if (p_hs) begin if (hs_run != HE - HS) hs_bad++; hs_run = 0; end
         if (vsync) vs_run++; else if (p_vs) begin if (vs_run != VN * C) vs_bad++; vs_run = 0; end
         if (csync) cs_run++; else if (p_cs) begin if (cs_run == WL) wide++; cs_run = 0; end
         if (eop) begin
            if (!p_eo) begin
               eo_rise++;
               if (first_rise < 0) first_rise = edges; else rise_gap = edges - first_rise;
            end
            eo_run++;
         end else if (p_eo) begin
            if (eo_run != C) eo_bad++;
            eo_run = 0;
         end
         if (!load_n) begin
            if (last_low >= 0 && edges - last_low != LG) ld_bad++;
            last_low = edges;
         end
         p_hs = hsync; p_vs = vsync; p_cs = csync; p_eo = eop;
      end
      check_eq("R2", rise_gap, F, "clocks between end-of-page rises (frame length)");
      check_eq("R3", errcnt[3], 0, "hsync mismatches");
      check_eq("R3", hs_bad, 0, "hsync pulses of wrong width");
      check_eq("R4", errcnt[4], 0, "blank_n mismatches");
      check_eq("R6", errcnt[6], 0, "vsync mismatches");
      check_eq("R6", vs_bad, 0, "vsync pulses of wrong width");
      check_eq("R7", errcnt[7], 0, "csync mismatches");
      check_eq("R7", wide, 2 * VN, "wide composite pulses in two frames");
      check_eq("R8", errcnt[8], 0, "cblank mismatches");
      check_eq("R9", errcnt[9], 0, "cursor_line mismatches");
      check_eq("R10", errcnt[10], 0, "eop mismatches");
      check_eq("R10", eo_rise, 2, "eop pulses in two frames");
      check_eq("R10", eo_bad, 0, "eop pulses of wrong width");
      check_eq("R11", errcnt[11], 0, "load_n mismatches");
      check_eq("R11", ld_bad, 0, "load strobes at wrong spacing");
   endtask

   task automatic test_fifty_hz();
      int p;
      p = 2 * F + (3 * S + 10) * C + 5;
      wait_edges(p + 1);
      check_eq("R5", int'(f_blank_n), 0, "50 Hz blank_n on scan 10 of row 3");
      check_eq("R4", int'(blank_n), 1, "60 Hz blank_n on scan 10 of row 3");
      p = 2 * F + (3 * S + 8) * C + 5;
      wait_edges(p + F + 1);
      check_eq("R5", int'(f_blank_n), 1, "50 Hz blank_n on scan 8 of row 3");
      check_eq("R5", errcnt[5], 0, "50 Hz blank_n mismatches");
   endtask

   task automatic test_blink();
      wait_edges(VB_BASE + 11 * F + 5);
      check_eq("R12", errcnt[12], 0, "blink mismatches");
      check_eq("R12", toggles, 2, "blink toggles after twelve vertical intervals");
      check_eq("R12", toggle_at[0], VB_BASE + 5 * F + 1, "edge of first blink toggle");
      check_eq("R12", toggle_at[1] - toggle_at[0], (BD / 2) * F, "clocks between blink toggles");
   endtask

   task automatic test_midreset();
      int total;
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R1", int'({hsync, vsync, csync, eop, cursor_line, blink}), 0, "outputs after mid-frame reset");
      check_eq("R1", int'({cblank, load_n, blank_n}), 6, "cblank/load_n/blank_n after mid-frame reset");
      rst = 1'b0;
      repeat (F + 10) @(negedge clk);
      total = 0;
      for (int k = 1; k <= 12; k++) total += errcnt[k];
      check_eq("R2", total, 0, "mismatches after counters restart from zero");
   endtask

   initial begin
      for (int k = 1; k <= 12; k++) errcnt[k] = 0;
      for (int k = 0; k < 4; k++) toggle_at[k] = 0;
      test_reset();
      rst = 1'b0;
      test_raster();
      test_fifty_hz();
      test_blink();
      test_midreset();
      check_eq("R1", errcnt[1], 0, "reset-state mismatches seen by monitor");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL R2 watchdog expired: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule